// File: doc/BRIEF.md
# Programmable-Length Recirculating Line Buffer

This block delays a stream of video samples by a run-time programmable number of clock cycles. Every cycle one sample enters on the data input and one sample leaves on the data output. The delay is set by a length code held in a load-strobed register. The delay is the code plus two cycles, so the shortest delay is two cycles. The storage is a ring of memory words addressed by a write pointer and a read pointer. Each pointer wraps after code + 2 positions and can be cleared on its own with an active-low synchronous clear.

A write-enable input picks the mode. With it low, the block is a plain programmable delay. With it high, the write pointer stops and incoming samples are discarded, while the read pointer keeps walking the ring. The stored line is then played back over and over. Leaving this mode needs both pointer clears together, which realigns the pointers. A read-enable input must stay low in normal operation. Raising it freezes the read pointer and the output.

A build-time cascade option joins two memory banks into a single store of twice the depth. This adds one bit to the length code and roughly doubles the longest delay.

Top module: `line_recirc_delay`

## Requirements
- R1: On a rising clock edge with `len_ld_n` low, `len_code` is captured into the length register. While `len_ld_n` is high, changes on `len_code` have no effect on the delay.
- R2: With write enable and read enable both low, and after a joint pointer clear, a sample presented on `din` at clock edge t appears on `dout` just after edge t + code + 2. Code 0 gives a two-cycle delay.
- R3: The all-ones code gives the longest delay, 2^W + 1 cycles, where W is the width of `len_code`.
- R4: With `wr_en_n` high, the write pointer holds and `din` is discarded. `dout` replays the last code + 2 samples written, repeating with a period of code + 2 cycles.
- R5: `wptr_rst_n` low at an edge sets the write pointer to location 0, and `rptr_rst_n` low sets the read pointer to 0. Asserting both at one edge realigns the pointers, so R2 holds for samples entered from the following edge on. This includes the return from recirculation.
- R6: With `rd_en_n` high, the read pointer does not advance and `dout` keeps its value.
- R7: While `rst_n` is low, `dout` is 0, the length register is 0 and both pointers are at location 0.
- R8: With CASCADE = 1, two banks form one store. `len_code` is LEN_W + 1 bits wide, and the delay is still code + 2, including delays that cross from the first bank into the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_ld_n | input | 1 | Active-low strobe that loads the length register |
| len_code | input | LEN_W+CASCADE | Length code; delay = code + 2 |
| wr_en_n | input | 1 | Low: delay mode; high: recirculate mode |
| rd_en_n | input | 1 | Active-low read enable, held low in normal use |
| wptr_rst_n | input | 1 | Active-low synchronous write-pointer clear |
| rptr_rst_n | input | 1 | Active-low synchronous read-pointer clear |
| din | input | DATA_W | Sample input |
| dout | output | DATA_W | Registered sample output |

## Verification
The bench aims at the shortest ring (code 0). A pointer that wraps one place early or late would give three cycles or one cycle of delay instead of two. It also drives the all-ones code and a long cascaded delay that crosses the bank boundary; a pointer too narrow, or a bank select that is off, would send stale or wrong words. During recirculation it keeps driving random data. Any write that leaks through, or a write pointer that keeps moving, breaks the replay period. It also holds the read enable high and clears the pointers after a mode change, catching a read that moves while disabled or a realignment that leaves the two pointers offset.

// File: rtl/lrd_pkg.sv
package lrd_pkg;

  // Extra ring positions beyond the length code: delay = code + RING_OFS.
  localparam int unsigned RING_OFS = 2;

  // Words in one bank: enough to hold the longest ring of a single bank.
  function automatic int unsigned bank_words(int unsigned len_w);
    return (32'd1 << len_w) + RING_OFS;
  endfunction

endpackage

// File: rtl/lrd_len_reg.sv
module lrd_len_reg #(
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic [LW-1:0] code_i,
  output logic [LW-1:0] code_o
);

  logic [LW-1:0] len_q;
  logic [LW-1:0] len_nxt;

  always_comb begin
    len_nxt = len_q;
    if (!ld_n) begin
      len_nxt = code_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else begin
      len_q <= len_nxt;
    end
  end

  assign code_o = len_q;

endmodule

// File: rtl/lrd_ptr.sv
module lrd_ptr #(
  parameter int unsigned PW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          adv,
  input  logic [PW-1:0] last,
  output logic [PW-1:0] ptr_o
);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt = ptr_q;
    if (!clr_n) begin
      ptr_nxt = '0;
    end else if (adv) begin
      if (ptr_q >= last) begin
        ptr_nxt = '0;
      end else begin
        ptr_nxt = ptr_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_nxt;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/lrd_bank.sv
module lrd_bank #(
  parameter int unsigned DW    = 12,
  parameter int unsigned PW    = 9,
  parameter int unsigned AW    = 9,
  parameter int unsigned WORDS = 258,
  parameter int unsigned BASE  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [PW-1:0] raddr,
  output logic          rhit,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];
  logic [PW:0]   w_off;
  logic [PW:0]   r_off;
  logic          w_hit;
  logic [AW-1:0] w_loc;
  logic [AW-1:0] r_loc;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] rd_nxt;

  // Offset of the global pointer from this bank's first word.
  always_comb begin
    w_off = {1'b0, waddr} - (PW+1)'(BASE);
    r_off = {1'b0, raddr} - (PW+1)'(BASE);
    w_hit = !w_off[PW] && (w_off < (PW+1)'(WORDS));
    rhit  = !r_off[PW] && (r_off < (PW+1)'(WORDS));
    w_loc = AW'(w_off);
    r_loc = AW'(r_off);
  end

  // Storage: no reset, written only in delay mode at the write pointer.
  always_ff @(posedge clk) begin
    if (we && w_hit) begin
      mem[w_loc] <= wdata;
    end
  end

  // Read register: old word is returned when read and write share an address.
  always_comb begin
    rd_nxt = rd_q;
    if (re) begin
      rd_nxt = mem[r_loc];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_nxt;
    end
  end

  assign rdata = rd_q;

endmodule

// File: rtl/line_recirc_delay.sv
module line_recirc_delay #(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned CASCADE = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       len_ld_n,
  input  logic [LEN_W+CASCADE-1:0]   len_code,
  input  logic                       wr_en_n,
  input  logic                       rd_en_n,
  input  logic                       wptr_rst_n,
  input  logic                       rptr_rst_n,
  input  logic [DATA_W-1:0]          din,
  output logic [DATA_W-1:0]          dout
);

  localparam int unsigned LW    = LEN_W + CASCADE;
  localparam int unsigned NB    = 1 + CASCADE;
  localparam int unsigned WORDS = lrd_pkg::bank_words(LEN_W);
  localparam int unsigned TOT   = NB * WORDS;
  localparam int unsigned PW    = $clog2(TOT);
  localparam int unsigned AW    = $clog2(WORDS);

  logic [LW-1:0]     len_q;
  logic [PW-1:0]     ring_last;
  logic [PW-1:0]     wptr;
  logic [PW-1:0]     rptr;
  logic              wr_act;
  logic              rd_act;
  logic [NB-1:0]     rhit;
  logic [NB-1:0]     rsel_q;
  logic [NB-1:0]     rsel_nxt;
  logic [DATA_W-1:0] bank_rd [NB];
  logic [DATA_W-1:0] dout_mux;

  assign wr_act = !wr_en_n;
  assign rd_act = !rd_en_n;

  lrd_len_reg #(.LW(LW)) u_len (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_n   (len_ld_n),
    .code_i (len_code),
    .code_o (len_q)
  );

  // Ring spans code + 2 positions: last position index is code + 1.
  assign ring_last = PW'(len_q) + PW'(1);

  lrd_ptr #(.PW(PW)) u_wptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_n (wptr_rst_n),
    .adv   (wr_act),
    .last  (ring_last),
    .ptr_o (wptr)
  );

  lrd_ptr #(.PW(PW)) u_rptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_n (rptr_rst_n),
    .adv   (rd_act),
    .last  (ring_last),
    .ptr_o (rptr)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    lrd_bank #(
      .DW    (DATA_W),
      .PW    (PW),
      .AW    (AW),
      .WORDS (WORDS),
      .BASE  (g * WORDS)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_act),
      .waddr (wptr),
      .wdata (din),
      .re    (rd_act),
      .raddr (rptr),
      .rhit  (rhit[g]),
      .rdata (bank_rd[g])
    );
  end

  // Bank select follows the read data it belongs to.
  always_comb begin
    rsel_nxt = rsel_q;
    if (rd_act) begin
      rsel_nxt = rhit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q <= '0;
    end else begin
      rsel_q <= rsel_nxt;
    end
  end

  always_comb begin
    dout_mux = '0;
    for (int i = 0; i < NB; i++) begin
      dout_mux = dout_mux | (bank_rd[i] & {DATA_W{rsel_q[i]}});
    end
  end

  assign dout = dout_mux;

endmodule

// File: rtl/line_recirc_delay_chk.sv
module line_recirc_delay_chk #(
  parameter int unsigned LW     = 8,
  parameter int unsigned PW     = 9,
  parameter int unsigned DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              len_ld_n,
  input logic [LW-1:0]     len_code,
  input logic              wr_en_n,
  input logic              rd_en_n,
  input logic              wptr_rst_n,
  input logic              rptr_rst_n,
  input logic [DATA_W-1:0] dout,
  input logic [LW-1:0]     len_q,
  input logic [PW-1:0]     wptr,
  input logic [PW-1:0]     rptr
);

  AST_LEN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !len_ld_n |=> (len_q == $past(len_code))); // R1

  AST_LEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    len_ld_n |=> $stable(len_q)); // R1

  AST_WPTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_n && wptr_rst_n) |=> $stable(wptr)); // R4

  AST_WPTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !wptr_rst_n |=> (wptr == '0)); // R5

  AST_RPTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !rptr_rst_n |=> (rptr == '0)); // R5

  AST_RPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_n && rptr_rst_n) |=> $stable(rptr)); // R6

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_n |=> $stable(dout)); // R6

endmodule

bind line_recirc_delay line_recirc_delay_chk #(
  .LW     (LW),
  .PW     (PW),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .len_ld_n   (len_ld_n),
  .len_code   (len_code),
  .wr_en_n    (wr_en_n),
  .rd_en_n    (rd_en_n),
  .wptr_rst_n (wptr_rst_n),
  .rptr_rst_n (rptr_rst_n),
  .dout       (dout),
  .len_q      (len_q),
  .wptr       (wptr),
  .rptr       (rptr)
);

// File: tb/test_line_recirc_delay.sv
module test_line_recirc_delay;

  localparam int DW    = 12;
  localparam int LEN_W = 8;
  localparam int LW1   = LEN_W + 1;
  localparam int MAXC  = 32768;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n;
  logic           len_ld_n;
  logic           wr_en_n;
  logic           rd_en_n;
  logic           wptr_rst_n;
  logic           rptr_rst_n;
  logic [LW1-1:0] code;
  logic [DW-1:0]  din;
  logic [DW-1:0]  dout0;
  logic [DW-1:0]  dout1;

  line_recirc_delay #(.DATA_W(DW), .LEN_W(LEN_W), .CASCADE(0)) i_line_recirc_delay (
    .clk        (clk),
    .rst_n      (rst_n),
    .len_ld_n   (len_ld_n),
    .len_code   (code[LEN_W-1:0]),
    .wr_en_n    (wr_en_n),
    .rd_en_n    (rd_en_n),
    .wptr_rst_n (wptr_rst_n),
    .rptr_rst_n (rptr_rst_n),
    .din        (din),
    .dout       (dout0)
  );

  line_recirc_delay #(.DATA_W(DW), .LEN_W(LEN_W), .CASCADE(1)) i_line_recirc_delay_cas (
    .clk        (clk),
    .rst_n      (rst_n),
    .len_ld_n   (len_ld_n),
    .len_code   (code),
    .wr_en_n    (wr_en_n),
    .rd_en_n    (rd_en_n),
    .wptr_rst_n (wptr_rst_n),
    .rptr_rst_n (rptr_rst_n),
    .din        (din),
    .dout       (dout1)
  );

  int            cyc   = 0;
  int            vfrom = 1;
  int            r0    = 2;
  int            r1    = 2;
  int            n_chk = 0;
  int            n_err = 0;
  bit            chk_on = 1'b0;
  bit            done   = 1'b0;
  string         tag0 = "R2";
  string         tag1 = "R2";
  logic [DW-1:0] hist [MAXC];
  bit            wr   [MAXC];

  // Expected output after edge e for ring length r: the sample last written
  // at an edge congruent to e modulo r, no earlier than the last realignment.
  function automatic logic [DW-1:0] exp_at(int e, int r, output bit ok);
    int j;
    j = e - r;
    while (j >= vfrom && !wr[j]) j = j - r;
    ok = (j >= vfrom);
    return ok ? hist[j] : '0;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit            ok;
    logic [DW-1:0] e;
    if (cyc + 1 < MAXC) begin
      hist[cyc+1] = din;
      wr[cyc+1]   = !wr_en_n;
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    if (chk_on && cyc < MAXC) begin
      e = exp_at(cyc, r0, ok);
      if (ok) check(tag0, dout0, e);
      e = exp_at(cyc, r1, ok);
      if (ok) check(tag1, dout1, e);
    end
  endtask

  task automatic run(int n, bit rnd_code);
    for (int i = 0; i < n; i++) begin
      din = DW'($urandom);
      if (rnd_code) code = LW1'($urandom);
      step();
    end
  endtask

  task automatic load_len(int v);
    chk_on   = 1'b0;
    code     = LW1'(v);
    len_ld_n = 1'b0;
    step();
    len_ld_n = 1'b1;
    r0 = (v % (1 << LEN_W)) + 2;
    r1 = v + 2;
  endtask

  task automatic realign();
    chk_on     = 1'b0;
    wr_en_n    = 1'b0;
    wptr_rst_n = 1'b0;
    rptr_rst_n = 1'b0;
    step();
    wptr_rst_n = 1'b1;
    rptr_rst_n = 1'b1;
    vfrom  = cyc + 1;
    chk_on = 1'b1;
  endtask

  task automatic set_tags(string t0, string t1);
    tag0 = t0;
    tag1 = t1;
  endtask

  initial begin
    logic [DW-1:0] h0;
    logic [DW-1:0] h1;
    void'($urandom(32'd13579));
    rst_n      = 1'b0;
    len_ld_n   = 1'b1;
    wr_en_n    = 1'b0;
    rd_en_n    = 1'b0;
    wptr_rst_n = 1'b1;
    rptr_rst_n = 1'b1;
    code       = '0;
    din        = '0;
    repeat (3) @(negedge clk);
    // R7: outputs cleared by the asynchronous reset
    check("R7", dout0, '0);
    check("R7", dout1, '0);
    rst_n = 1'b1;

    // R2: shortest ring, code 0 gives two cycles
    load_len(0);
    realign();
    set_tags("R2", "R2");
    run(40, 1'b0);

    // R1 / R5: load a new length then realign
    load_len(5);
    realign();
    set_tags("R5", "R5");
    run(12, 1'b0);
    set_tags("R1", "R1");
    run(40, 1'b0);

    // R1: len_code toggles with the load strobe high, random lengths
    for (int k = 0; k < 4; k++) begin
      load_len(int'($urandom % 512));
      realign();
      set_tags("R1", "R8");
      run(3 * r1 + 10, 1'b1);
    end

    // R4: recirculation on a short ring, then R5 realign on exit
    load_len(9);
    realign();
    set_tags("R2", "R2");
    run(30, 1'b0);
    wr_en_n = 1'b1;
    set_tags("R4", "R4");
    run(60, 1'b0);
    realign();
    set_tags("R5", "R5");
    run(40, 1'b0);

    // R4 / R8: recirculation across the bank boundary of the cascaded store
    load_len(300);
    realign();
    set_tags("R2", "R8");
    run(320, 1'b0);
    wr_en_n = 1'b1;
    set_tags("R4", "R4");
    run(700, 1'b0);
    realign();
    set_tags("R5", "R8");
    run(350, 1'b0);

    // R3 / R8: all-ones code
    load_len(511);
    realign();
    set_tags("R3", "R8");
    run(2 * 513 + 20, 1'b0);

    // R6: read enable high freezes the output
    chk_on = 1'b0;
    h0 = dout0;
    h1 = dout1;
    rd_en_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      din = DW'($urandom);
      step();
      check("R6", dout0, h0);
      check("R6", dout1, h1);
    end
    rd_en_n = 1'b0;
    load_len(3);
    realign();
    set_tags("R2", "R2");
    run(30, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule